// File: doc/BRIEF.md
# Asynchronous NRZ Serial Transmitter

This block drives one serial output line with asynchronous non-return-to-zero frames. Software-side logic writes a character into a one-entry holding buffer. That buffer feeds a frame shifter, so a second character can wait while the first is still being sent. Each frame has the following parts, in this order:

- a low start bit;
- the configured number of data bits, least significant first;
- an optional parity bit;
- an optional address marker bit;
- one or two high stop bits.

The bit time is taken from a divisor input. Two status outputs report whether the buffer is free and whether the shifter is completely idle. A transmit interrupt line follows the buffer-free flag, gated by its own enable. The transmitter has its own enable and does not depend on any receiver, so it can run alongside one in full duplex.

Top module: `nrz_tx`

## Requirements
- R1: One bit lasts 16 clock cycles when `baud_div` is 0, and (`baud_div`+1)*8 clock cycles otherwise.
- R2: A frame is a 0 start bit, then `word_len`+1 data bits sent LSB first, then the optional fields, then the stop bits at 1. The line is 1 whenever no frame is being sent.
- R3: With `parity_en` set, a parity bit follows the data. It is computed over the configured data bits only. When `parity_odd` is 0 the bit makes the count of ones even; when `parity_odd` is 1 it makes the count odd.
- R4: With `two_stop` set, the frame ends with two stop bits; otherwise it ends with one.
- R5: With `addr_mode` set, one more bit is sent after the data and after any parity bit. It equals the `wr_addr` value captured with the character.
- R6: A write (`wr` high while `ready` is high) captures the character and drops `ready`. The character moves to the shifter on the first cycle in which the shifter is free, either idle or finishing its last stop bit, and `ready` rises again on that cycle. A waiting character starts immediately after the previous frame, with no idle gap.
- R7: A write made while `ready` is low is ignored, and the waiting character is left unchanged.
- R8: `empty` is high only when the shifter is idle and no character is waiting. It rises on the cycle after the last stop bit ends when the buffer is empty, and it stays low if a character was waiting.
- R9: `irq` is high exactly when `irq_en` is high and `ready` is high.
- R10: While `tx_en` is low, the line is held at 1, any frame in progress stops, and no character leaves the buffer. The buffer is kept and starts sending once `tx_en` returns high.
- R11: After reset, `txd`, `ready` and `empty` are 1. `irq` is 1 only if `irq_en` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| irq_en | input | 1 | Transmit interrupt enable |
| baud_div | input | DIV_W | Bit-time divisor |
| word_len | input | $clog2(MAXD) | Data bits per frame minus one |
| parity_en | input | 1 | Insert a parity bit |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop | input | 1 | Send two stop bits |
| addr_mode | input | 1 | Insert the address marker bit |
| wr | input | 1 | Write strobe for the holding buffer |
| wr_data | input | MAXD | Character to send |
| wr_addr | input | 1 | Address marker value for this character |
| ready | output | 1 | Holding buffer can accept a character |
| empty | output | 1 | Shifter idle and buffer empty |
| irq | output | 1 | Transmit interrupt request |
| txd | output | 1 | Serial output line |

## Verification
The assertions assume that `wr` is a single-cycle strobe issued only from ordinary clocked drive. They also assume that `tx_en` is the only control that changes in the middle of a frame. The frame-format inputs and the divisor must stay fixed from a write until that frame has gone out. The stimulus meets these conditions by changing configuration only while `empty` is high. It randomizes data, address flag, length, parity, stop count and a small range of divisors between frames. Directed cases cover back-to-back characters, writes while full, and disabling with a character waiting.

// File: rtl/nrz_tx.sv
module nrz_tx #(
  parameter int DIV_W = 16,
  parameter int MAXD  = 8,
  localparam int LENW = $clog2(MAXD),
  localparam int CW   = DIV_W + 4,
  localparam int FW   = MAXD + 5,
  localparam int LW   = $clog2(FW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             irq_en,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [LENW-1:0]  word_len,
  input  logic             parity_en,
  input  logic             parity_odd,
  input  logic             two_stop,
  input  logic             addr_mode,
  input  logic             wr,
  input  logic [MAXD-1:0]  wr_data,
  input  logic             wr_addr,
  output logic             ready,
  output logic             empty,
  output logic             irq,
  output logic             txd
);
  logic [MAXD-1:0] buf_q;
  logic            buf_addr, bufv, busy;
  logic [CW-1:0]   cnt, period;
  logic [LW-1:0]   left, nbits, pos;
  logic [FW-1:0]   shreg, frame;
  logic            par;

  assign period = (baud_div == '0) ? CW'(16) : (CW'(baud_div) + CW'(1)) << 3;

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    par      = parity_odd;
    for (int i = 0; i < MAXD; i++) begin
      if (i <= int'(word_len)) begin
        frame[i+1] = buf_q[i];
        par        = par ^ buf_q[i];
      end
    end
    pos = LW'(word_len) + LW'(2);
    if (parity_en) begin
      frame[pos] = par;
      pos        = pos + LW'(1);
    end
    if (addr_mode) begin
      frame[pos] = buf_addr;
      pos        = pos + LW'(1);
    end
    nbits = pos + LW'(1) + LW'(two_stop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q    <= '0;
      buf_addr <= 1'b0;
      bufv     <= 1'b0;
      busy     <= 1'b0;
      cnt      <= '0;
      left     <= '0;
      shreg    <= '1;
    end else begin
      if (wr && !bufv) begin
        buf_q    <= wr_data;
        buf_addr <= wr_addr;
        bufv     <= 1'b1;
      end
      if (!tx_en) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (busy && cnt != period - CW'(1)) begin
        cnt <= cnt + CW'(1);
      end else if (busy && left != LW'(1)) begin
        cnt   <= '0;
        shreg <= {1'b1, shreg[FW-1:1]};
        left  <= left - LW'(1);
      end else if (bufv) begin
        busy  <= 1'b1;
        cnt   <= '0;
        shreg <= frame;
        left  <= nbits;
        bufv  <= 1'b0;
      end else begin
        busy <= 1'b0;
      end
    end
  end

  assign ready = !bufv;
  assign empty = !bufv && !busy;
  assign irq   = irq_en && ready;
  assign txd   = !(tx_en && busy) || shreg[0];
endmodule

module nrz_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic irq_en,
  input logic wr,
  input logic ready,
  input logic empty,
  input logic irq,
  input logic txd
);
  // R6
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(wr));
  // R8
  empty_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(empty) |-> $past(wr));
  // R8
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> ready);
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
  // R10
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> txd);
  // R10
  hold_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(tx_en));
endmodule

bind nrz_tx nrz_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .irq_en(irq_en), .wr(wr),
  .ready(ready), .empty(empty), .irq(irq), .txd(txd)
);

// File: tb/sim_nrz_tx.sv
`timescale 1ns/1ps
module sim_nrz_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 1'b1, irq_en = 1'b1;
  logic [15:0] baud_div = '0;
  logic [2:0] word_len = 3'd7;
  logic parity_en = 0, parity_odd = 0, two_stop = 0, addr_mode = 0;
  logic wr = 0, wr_addr = 0;
  logic [7:0] wr_data = '0;
  logic ready, empty, irq, txd;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  nrz_tx u0 (.clk(clk), .rst_n(rst_n), .tx_en(tx_en), .irq_en(irq_en), .baud_div(baud_div),
    .word_len(word_len), .parity_en(parity_en), .parity_odd(parity_odd), .two_stop(two_stop),
    .addr_mode(addr_mode), .wr(wr), .wr_data(wr_data), .wr_addr(wr_addr),
    .ready(ready), .empty(empty), .irq(irq), .txd(txd));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pd();
    return (baud_div == 0) ? 16 : (int'(baud_div) + 1) * 8;
  endfunction

  function automatic logic [15:0] mkframe(input logic [7:0] d, input logic a, output int n);
    logic [15:0] f;
    int k;
    logic p;
    f = '1; f[0] = 1'b0; k = 1; p = parity_odd;
    for (int i = 0; i <= int'(word_len); i++) begin
      f[k] = d[i]; p = p ^ d[i]; k++;
    end
    if (parity_en) begin f[k] = p; k++; end
    if (addr_mode) begin f[k] = a; k++; end
    n = k + 1 + int'(two_stop);
    return f;
  endfunction

  task automatic put(input logic [7:0] d, input logic a);
    @(negedge clk); wr = 1; wr_data = d; wr_addr = a;
    @(negedge clk); wr = 0;
  endtask

  // called at the edge on which the frame starts
  task automatic check_frame(input logic [15:0] f, input int n, input bit exp_empty);
    int p;
    p = pd();
    for (int i = 0; i < n; i++) begin
      repeat (i == 0 ? p / 2 : p) @(posedge clk);
      #1 chk($sformatf("R2/R3/R4/R5 bit %0d", i), int'(txd), int'(f[i]));
    end
    repeat (p / 2 - 1) @(posedge clk);
    #1 chk("R8 empty before last stop ends", int'(empty), 0);
    @(posedge clk);
    #1 chk("R8 empty after frame", int'(empty), int'(exp_empty));
  endtask

  task automatic send(input logic [7:0] d, input logic a);
    logic [15:0] f;
    int n;
    f = mkframe(d, a, n);
    put(d, a);
    @(posedge clk);
    #1 chk("R6 ready after move", int'(ready), 1);
    check_frame(f, n, 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] fa, fb;
    int na, nb;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 chk("R11 txd", int'(txd), 1);
    chk("R11 ready", int'(ready), 1);
    chk("R11 empty", int'(empty), 1);
    chk("R9 irq at reset", int'(irq), 1);
    rst_n = 1;

    // R1 bit period with divisor 5 -> 48 cycles
    baud_div = 16'd5;
    put(8'h01, 0);
    @(posedge clk);
    repeat (47) @(posedge clk);
    #1 chk("R1 start still low at P-1", int'(txd), 0);
    @(posedge clk);
    #1 chk("R1 data bit at P", int'(txd), 1);
    while (!empty) @(posedge clk);

    // R1 divisor 0 and 1 both give 16
    baud_div = 16'd0; send(8'hA5, 0);
    baud_div = 16'd1; send(8'h3C, 0);

    // R3 parity even and odd, R4 two stops, R5 address bit
    parity_en = 1; parity_odd = 0; send(8'h07, 0);
    parity_odd = 1; send(8'h07, 0);
    two_stop = 1; addr_mode = 1; send(8'h5A, 1);
    word_len = 3'd0; send(8'hFE, 0);
    parity_en = 0; two_stop = 0; addr_mode = 0; word_len = 3'd7;

    // R6 back-to-back, R8 empty stays low
    fa = mkframe(8'hC3, 0, na);
    fb = mkframe(8'h96, 0, nb);
    put(8'hC3, 0);
    @(posedge clk);
    fork
      check_frame(fa, na, 1'b0);
      begin
        @(negedge clk); wr = 1; wr_data = 8'h96;
        @(negedge clk); wr = 0;
        #1 chk("R6 ready low while waiting", int'(ready), 0);
        chk("R9 irq low while waiting", int'(irq), 0);
      end
    join
    check_frame(fb, nb, 1'b1);

    // R10 disabled holds buffer, R7 write while full ignored
    @(negedge clk); tx_en = 0;
    put(8'h81, 0);
    put(8'h18, 0);
    repeat (40) @(posedge clk);
    #1 chk("R10 line idle when disabled", int'(txd), 1);
    chk("R10 buffer held", int'(ready), 0);
    chk("R8 empty low with char waiting", int'(empty), 0);
    @(negedge clk); irq_en = 0;
    @(posedge clk); #1 chk("R9 irq with enable low", int'(irq), 0);
    @(negedge clk); irq_en = 1; tx_en = 1;
    fa = mkframe(8'h81, 0, na);
    @(posedge clk);
    check_frame(fa, na, 1'b1);   // R7: first character sent, not the second

    // R10 abort mid-frame
    put(8'h00, 0);
    repeat (20) @(posedge clk);
    @(negedge clk); tx_en = 0;
    @(posedge clk); #1 chk("R10 abort line high", int'(txd), 1);
    repeat (2) @(posedge clk);
    #1 chk("R10 abort empty", int'(empty), 1);
    @(negedge clk); tx_en = 1;

    // random frames
    for (int k = 0; k < 24; k++) begin
      baud_div   = 16'($urandom_range(0, 4));
      word_len   = 3'($urandom_range(0, 7));
      parity_en  = 1'($urandom_range(0, 1));
      parity_odd = 1'($urandom_range(0, 1));
      two_stop   = 1'($urandom_range(0, 1));
      addr_mode  = 1'($urandom_range(0, 1));
      send(8'($urandom), 1'($urandom_range(0, 1)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule